// File: doc/BRIEF.md
# SPI Controller Register and FIFO Front End

This block sits between a 32-bit memory-mapped register bus and a serial transfer engine. Software programs configuration, clock divider, interrupt enables and FIFO thresholds through word-aligned registers. It loads outgoing words into a transmit FIFO and drains incoming words from a receive FIFO. Both FIFOs are eight words deep and 32 bits wide. The engine pops transmit words and pushes receive words through its own side of the block. It also reports the end of a transfer with a one-cycle pulse.

Engine events and FIFO fill levels are gathered into a sticky status register. Software clears each status bit by writing a one to it. A single interrupt line is raised when any enabled status bit is set. Every bus access completes in the cycle it is presented: read data is combinational from the registered state, and writes and receive pops take effect at the following clock edge.

Top module: `spi_regfront`

## Requirements
- R1: Register word offsets (byte address) are config 0x00 (32 bits), divider 0x04 (low 16 bits), command 0x08 (32 bits), status 0x0C, interrupt enable 0x10 (low 5 bits), threshold 0x14 (low 8 bits, reset 0x10), fill counts 0x18, transmit data 0x1C and receive data 0x20. Config and divider are driven to the engine as stored, unused bits read as 0, and all stored registers reset to 0 except the threshold.
- R2: A write to the command register presents the written value on `eng_cmd` and raises `eng_cmd_go` for exactly the one cycle after the write edge. It also sets status bit 0 (pending), which clears again when `eng_done` is seen.
- R3: The fill-count register reads the receive FIFO level in bits [3:0] and the transmit FIFO level in bits [7:4]. The engine receives transmit words in the order they were written.
- R4: A write to transmit data while the transmit FIFO holds 8 words is dropped: the level stays 8 and the word never reaches the engine.
- R5: A read of receive data returns the oldest word and removes it. When the receive FIFO is empty, the read returns 0 and the levels do not change.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it alone. When a set condition is present in the same cycle as the clear, the set wins.
- R7: Status bit 2 sets while the transmit level is at or below the transmit threshold, which is held in threshold bits [3:0].
- R8: Status bit 3 sets while the receive level is at or above the receive threshold, held in threshold bits [7:4]. It also sets when `eng_done` arrives while the receive FIFO is not empty.
- R9: Status bit 4 sets when the engine pops an empty transmit FIFO. Status bit 5 sets when the engine pushes into a full receive FIFO, and that word is discarded.
- R10: `irq` is the OR over enable bit k ANDed with status bit k+1, for k = 0..4. Pending (status bit 0) never drives `irq`.
- R11: An `eng_done` pulse sets status bit 1 (done).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| eng_cfg | output | 32 | Configuration word to the engine |
| eng_div | output | 16 | Clock divider to the engine |
| eng_cmd | output | 32 | Last command word written |
| eng_cmd_go | output | 1 | One-cycle start pulse after a command write |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_tx_pop | input | 1 | Engine consumes the oldest transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_done | input | 1 | Transfer-finished pulse |
| irq | output | 1 | Interrupt request |

## Verification
Read data and the oldest transmit word are combinational, so they are sampled 1 ns after the falling edge of the cycle that presents the access or pop. Writes, pops, pushes, event pulses and the command start pulse take effect at the next rising edge. Threshold status bits need one more edge, because they compare levels that are themselves registered. Every stimulus task therefore holds its inputs for one falling-to-falling interval and releases them, and the next task starts one full cycle later, after both edges have passed. This is also why `eng_cmd_go` is checked right as the write task returns and checked low one cycle later.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;
  localparam int CMP_W   = 8;
  localparam int NUM_ST  = 6;
  localparam int NUM_IEN = 5;

  localparam int REG_CFG  = 0;
  localparam int REG_DIV  = 1;
  localparam int REG_CMD  = 2;
  localparam int REG_STAT = 3;
  localparam int REG_IEN  = 4;
  localparam int REG_THR  = 5;
  localparam int REG_WCNT = 6;
  localparam int REG_TXD  = 7;
  localparam int REG_RXD  = 8;

  localparam int ST_PEND = 0;
  localparam int ST_DONE = 1;
  localparam int ST_TXT  = 2;
  localparam int ST_RXT  = 3;
  localparam int ST_TXU  = 4;
  localparam int ST_RXO  = 5;

  function automatic logic [CMP_W-1:0] lvl_step(logic [CMP_W-1:0] lvl, logic push, logic pop);
    return lvl + CMP_W'(push) - CMP_W'(pop);
  endfunction

  function automatic logic lvl_at_or_below(logic [CMP_W-1:0] lvl, logic [CMP_W-1:0] thr);
    return lvl <= thr;
  endfunction

  function automatic logic lvl_at_or_above(logic [CMP_W-1:0] lvl, logic [CMP_W-1:0] thr);
    return lvl >= thr;
  endfunction

  function automatic logic irq_from(logic [NUM_ST-1:0] st, logic [NUM_IEN-1:0] en);
    return |(st[NUM_ST-1:1] & en);
  endfunction
endpackage

// File: rtl/spi_regfront_fifo.sv
module spi_regfront_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok
);
  import spi_regfront_pkg::*;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level_q;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level_q == LVL_W'(DEPTH));
  assign empty   = (level_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign level   = level_q;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      level_q <= LVL_W'(lvl_step(CMP_W'(level_q), push_ok, pop_ok));
    end
  end
endmodule

// File: rtl/spi_regfront_stat.sv
module spi_regfront_stat
  import spi_regfront_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   tx_lvl,
  input  logic [LVL_W-1:0]   rx_lvl,
  input  logic [LVL_W-1:0]   tx_thr,
  input  logic [LVL_W-1:0]   rx_thr,
  input  logic               cmd_start,
  input  logic               eng_done,
  input  logic               tx_uf_ev,
  input  logic               rx_of_ev,
  input  logic [NUM_ST-1:0]  clr_mask,
  input  logic [NUM_IEN-1:0] int_en,
  output logic [NUM_ST-1:0]  status,
  output logic               irq
);
  logic [NUM_ST-1:0] status_q;
  logic [NUM_ST-1:0] set_vec;
  logic [NUM_ST-1:0] keep_vec;
  logic              tx_low;
  logic              rx_high;
  logic              done_with_rx;

  assign tx_low       = lvl_at_or_below(CMP_W'(tx_lvl), CMP_W'(tx_thr));
  assign rx_high      = lvl_at_or_above(CMP_W'(rx_lvl), CMP_W'(rx_thr));
  assign done_with_rx = eng_done && (rx_lvl != '0);

  always_comb begin
    set_vec          = '0;
    set_vec[ST_PEND] = cmd_start;
    set_vec[ST_DONE] = eng_done;
    set_vec[ST_TXT]  = tx_low;
    set_vec[ST_RXT]  = rx_high || done_with_rx;
    set_vec[ST_TXU]  = tx_uf_ev;
    set_vec[ST_RXO]  = rx_of_ev;
    keep_vec          = ~clr_mask;
    keep_vec[ST_PEND] = keep_vec[ST_PEND] & ~eng_done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & keep_vec) | set_vec;
  end

  assign status = status_q;
  assign irq    = irq_from(status_q, int_en);
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_regfront_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int THR_RESET  = 'h10,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int IDX_W     = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] eng_cfg,
  output logic [DIV_W-1:0]  eng_div,
  output logic [DATA_W-1:0] eng_cmd,
  output logic              eng_cmd_go,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_tx_pop,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              eng_done,
  output logic              irq
);
  logic [IDX_W-1:0]     word_idx;
  logic                 wr_en, rd_en;
  logic                 wr_cfg, wr_div, wr_cmd, wr_stat, wr_ien, wr_thr, wr_txd, rd_rxd;

  logic [DATA_W-1:0]    cfg_q, cmd_q;
  logic [DIV_W-1:0]     div_q;
  logic [NUM_IEN-1:0]   ien_q;
  logic [2*LVL_W-1:0]   thr_q;
  logic                 cmd_go_q;

  logic [LVL_W-1:0]     tx_lvl, rx_lvl;
  logic                 tx_full, tx_empty, rx_full, rx_empty;
  logic                 tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic [DATA_W-1:0]    rx_head;
  logic                 tx_uf_ev, rx_of_ev;
  logic [NUM_ST-1:0]    clr_mask;
  logic [NUM_ST-1:0]    status_q;

  wire unused_bits = ^{bus_addr[1:0], tx_full, tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok};

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign wr_en    = bus_sel && bus_wr;
  assign rd_en    = bus_sel && !bus_wr;
  assign wr_cfg   = wr_en && (word_idx == IDX_W'(REG_CFG));
  assign wr_div   = wr_en && (word_idx == IDX_W'(REG_DIV));
  assign wr_cmd   = wr_en && (word_idx == IDX_W'(REG_CMD));
  assign wr_stat  = wr_en && (word_idx == IDX_W'(REG_STAT));
  assign wr_ien   = wr_en && (word_idx == IDX_W'(REG_IEN));
  assign wr_thr   = wr_en && (word_idx == IDX_W'(REG_THR));
  assign wr_txd   = wr_en && (word_idx == IDX_W'(REG_TXD));
  assign rd_rxd   = rd_en && (word_idx == IDX_W'(REG_RXD));

  assign tx_uf_ev = eng_tx_pop && tx_empty;
  assign rx_of_ev = eng_rx_push && rx_full;
  assign clr_mask = wr_stat ? bus_wdata[NUM_ST-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      div_q    <= '0;
      cmd_q    <= '0;
      ien_q    <= '0;
      thr_q    <= (2*LVL_W)'(THR_RESET);
      cmd_go_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= bus_wdata;
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
      if (wr_cmd) cmd_q <= bus_wdata;
      if (wr_ien) ien_q <= bus_wdata[NUM_IEN-1:0];
      if (wr_thr) thr_q <= bus_wdata[2*LVL_W-1:0];
      cmd_go_q <= wr_cmd;
    end
  end

  spi_regfront_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (wr_txd),
    .din     (bus_wdata),
    .pop     (eng_tx_pop),
    .dout    (eng_tx_data),
    .level   (tx_lvl),
    .full    (tx_full),
    .empty   (tx_empty),
    .push_ok (tx_push_ok),
    .pop_ok  (tx_pop_ok)
  );

  spi_regfront_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (eng_rx_push),
    .din     (eng_rx_data),
    .pop     (rd_rxd),
    .dout    (rx_head),
    .level   (rx_lvl),
    .full    (rx_full),
    .empty   (rx_empty),
    .push_ok (rx_push_ok),
    .pop_ok  (rx_pop_ok)
  );

  spi_regfront_stat #(.LVL_W(LVL_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_lvl    (tx_lvl),
    .rx_lvl    (rx_lvl),
    .tx_thr    (thr_q[LVL_W-1:0]),
    .rx_thr    (thr_q[2*LVL_W-1:LVL_W]),
    .cmd_start (wr_cmd),
    .eng_done  (eng_done),
    .tx_uf_ev  (tx_uf_ev),
    .rx_of_ev  (rx_of_ev),
    .clr_mask  (clr_mask),
    .int_en    (ien_q),
    .status    (status_q),
    .irq       (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (word_idx)
        IDX_W'(REG_CFG):  bus_rdata = cfg_q;
        IDX_W'(REG_DIV):  bus_rdata = DATA_W'(div_q);
        IDX_W'(REG_CMD):  bus_rdata = cmd_q;
        IDX_W'(REG_STAT): bus_rdata = DATA_W'(status_q);
        IDX_W'(REG_IEN):  bus_rdata = DATA_W'(ien_q);
        IDX_W'(REG_THR):  bus_rdata = DATA_W'(thr_q);
        IDX_W'(REG_WCNT): bus_rdata = DATA_W'({tx_lvl, rx_lvl});
        IDX_W'(REG_RXD):  bus_rdata = rx_empty ? '0 : rx_head;
        default:          bus_rdata = '0;
      endcase
    end
  end

  assign eng_cfg    = cfg_q;
  assign eng_div    = div_q;
  assign eng_cmd    = cmd_q;
  assign eng_cmd_go = cmd_go_q;
endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 4,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              eng_tx_pop,
  input logic              eng_done,
  input logic              eng_cmd_go,
  input logic              irq,
  input logic [LVL_W-1:0]  tx_lvl,
  input logic [LVL_W-1:0]  rx_lvl,
  input logic [5:0]        status,
  input logic [4:0]        int_en
);
  logic [ADDR_W-3:0] widx;
  logic              w_cmd, w_stat, w_txd, r_rxd;
  assign widx   = bus_addr[ADDR_W-1:2];
  assign w_cmd  = bus_sel && bus_wr && (widx == (ADDR_W-2)'(2));
  assign w_stat = bus_sel && bus_wr && (widx == (ADDR_W-2)'(3));
  assign w_txd  = bus_sel && bus_wr && (widx == (ADDR_W-2)'(7));
  assign r_rxd  = bus_sel && !bus_wr && (widx == (ADDR_W-2)'(8));
  wire unused_chk = ^{bus_addr[1:0], bus_wdata[DATA_W-1:2], bus_wdata[0]};

  AST_GO_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    w_cmd |=> eng_cmd_go); // R2
  AST_PEND_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    w_cmd |=> status[0]); // R2
  AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= LVL_W'(DEPTH)) && (rx_lvl <= LVL_W'(DEPTH))); // R3
  AST_FULL_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (w_txd && tx_lvl == LVL_W'(DEPTH) && !eng_tx_pop) |=> (tx_lvl == LVL_W'(DEPTH))); // R4
  AST_EMPTY_RX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rxd && rx_lvl == '0) |-> (bus_rdata == '0)); // R5
  AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && bus_wdata[1] && !eng_done) |=> !status[1]); // R6
  AST_UF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_pop && tx_lvl == '0) |=> status[4]); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == '0) |-> !irq); // R10
  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> status[1]); // R11
endmodule

bind spi_regfront spi_regfront_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .eng_tx_pop (eng_tx_pop),
  .eng_done   (eng_done),
  .eng_cmd_go (eng_cmd_go),
  .irq        (irq),
  .tx_lvl     (tx_lvl),
  .rx_lvl     (rx_lvl),
  .status     (status_q),
  .int_en     (ien_q)
);

// File: tb/spi_regfront_bench.sv
module spi_regfront_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] eng_cfg, eng_cmd, eng_tx_data;
  logic [15:0] eng_div;
  logic        eng_cmd_go, irq;
  logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_done = 1'b0;
  logic [31:0] eng_rx_data = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  localparam logic [7:0] A_CFG = 8'h00, A_DIV = 8'h04, A_CMD = 8'h08, A_STAT = 8'h0C,
    A_IEN = 8'h10, A_THR = 8'h14, A_WCNT = 8'h18, A_TXD = 8'h1C, A_RXD = 8'h20;

  always #5 clk = ~clk;

  spi_regfront u_spi_regfront (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_cfg(eng_cfg), .eng_div(eng_div),
    .eng_cmd(eng_cmd), .eng_cmd_go(eng_cmd_go), .eng_tx_data(eng_tx_data),
    .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_done(eng_done), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic pop_tx(output logic [31:0] d);
    @(negedge clk); eng_tx_pop = 1; #1 d = eng_tx_data;
    @(negedge clk); eng_tx_pop = 0;
  endtask

  task automatic push_rx(input logic [31:0] d);
    @(negedge clk); eng_rx_push = 1; eng_rx_data = d;
    @(negedge clk); eng_rx_push = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_STAT, v); chk("R7 reset status", v, 32'h04);
    rd(A_CFG, v);  chk("R1 reset cfg", v, 0);
    rd(A_THR, v);  chk("R1 reset thr", v, 32'h10);
    rd(A_WCNT, v); chk("R3 reset wcnt", v, 0);
    chk("R10 reset irq", irq, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_CFG, 32'hA5A5_0F0F); rd(A_CFG, v); chk("R1 cfg", v, 32'hA5A5_0F0F);
    chk("R1 eng_cfg", eng_cfg, 32'hA5A5_0F0F);
    wr(A_DIV, 32'h1234_0010); rd(A_DIV, v); chk("R1 div", v, 32'h10);
    chk("R1 eng_div", eng_div, 16'h0010);
    wr(A_IEN, 32'hFFFF_FFFF); rd(A_IEN, v); chk("R1 ien", v, 32'h1F);
    wr(A_IEN, 0);
    wr(A_THR, 32'h0000_FFFF); rd(A_THR, v); chk("R1 thr", v, 32'hFF);
    wr(A_THR, 32'h10);
  endtask

  task automatic t_cmd();
    logic [31:0] v;
    wr(A_STAT, 32'h3F);
    wr(A_CMD, 32'h00FF_0013);
    #1 chk("R2 go pulse", eng_cmd_go, 1);
    chk("R2 cmd value", eng_cmd, 32'h00FF_0013);
    @(negedge clk); #1 chk("R2 go one cycle", eng_cmd_go, 0);
    rd(A_STAT, v); chk("R2 pending set", v & 3, 1);
    done_pulse();
    rd(A_STAT, v); chk("R11 done set, R2 pending cleared", v & 3, 2);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); chk("R6 done cleared", v & 3, 0);
  endtask

  task automatic t_irq();
    wr(A_IEN, 32'h01);
    wr(A_CMD, 32'h1);
    chk("R10 pending not a source", irq, 0);
    done_pulse();
    chk("R10 done irq", irq, 1);
    wr(A_IEN, 0); chk("R10 masked", irq, 0);
    wr(A_IEN, 32'h01); wr(A_STAT, 32'h2); chk("R10 cleared", irq, 0);
    wr(A_IEN, 32'h02); chk("R10 tx thr irq", irq, 1);
    wr(A_IEN, 0);
  endtask

  task automatic t_txfifo();
    logic [31:0] v;
    wr(A_THR, 32'h12);
    for (int i = 0; i < 3; i++) wr(A_TXD, 32'hA000_0000 + i);
    wr(A_STAT, 32'h04);
    rd(A_STAT, v); chk("R7 above thr", v & 4, 0);
    rd(A_WCNT, v); chk("R3 wcnt tx3", v, 32'h30);
    pop_tx(v); chk("R3 order 0", v, 32'hA000_0000);
    rd(A_STAT, v); chk("R7 at thr", v & 4, 4);
    for (int i = 3; i < 9; i++) wr(A_TXD, 32'hA000_0000 + i);
    wr(A_TXD, 32'hDEAD_BEEF);
    rd(A_WCNT, v); chk("R4 full level", v, 32'h80);
    for (int i = 1; i < 9; i++) begin
      pop_tx(v); chk("R4 order after drop", v, 32'hA000_0000 + i);
    end
    rd(A_WCNT, v); chk("R3 tx drained", v, 0);
  endtask

  task automatic t_setwins();
    logic [31:0] v;
    wr(A_STAT, 32'h04);
    rd(A_STAT, v); chk("R6 set wins over clear", v & 4, 4);
  endtask

  task automatic t_underflow();
    logic [31:0] v;
    wr(A_STAT, 32'h10);
    pop_tx(v);
    rd(A_STAT, v); chk("R9 underflow", v & 32'h10, 32'h10);
    wr(A_IEN, 32'h08); chk("R10 underflow irq", irq, 1);
    wr(A_STAT, 32'h10); chk("R6 underflow cleared", irq, 0);
    wr(A_IEN, 0);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    wr(A_THR, 32'h22);
    wr(A_STAT, 32'h08);
    push_rx(32'hB100_0001);
    rd(A_STAT, v); chk("R8 below rx thr", v & 8, 0);
    push_rx(32'hB100_0002);
    rd(A_STAT, v); chk("R8 at rx thr", v & 8, 8);
    rd(A_WCNT, v); chk("R3 wcnt rx2", v, 32'h02);
    rd(A_RXD, v); chk("R5 rx order 0", v, 32'hB100_0001);
    rd(A_RXD, v); chk("R5 rx order 1", v, 32'hB100_0002);
    rd(A_RXD, v); chk("R5 empty read zero", v, 0);
    rd(A_WCNT, v); chk("R5 empty read no change", v, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(A_STAT, 32'h20);
    for (int i = 0; i < 9; i++) push_rx(32'hC000_0000 + i);
    rd(A_STAT, v); chk("R9 overflow", v & 32'h20, 32'h20);
    rd(A_WCNT, v); chk("R9 rx full", v, 32'h08);
    for (int i = 0; i < 8; i++) begin
      rd(A_RXD, v); chk("R9 overflow word dropped", v, 32'hC000_0000 + i);
    end
    rd(A_RXD, v); chk("R5 drained zero", v, 0);
  endtask

  task automatic t_done_rx();
    logic [31:0] v;
    wr(A_THR, 32'h82);
    push_rx(32'hD0D0_0001);
    wr(A_STAT, 32'h0F);
    rd(A_STAT, v); chk("R8 no rx thr", v & 8, 0);
    done_pulse();
    rd(A_STAT, v); chk("R8 done with data", v & 32'hA, 32'hA);
    rd(A_RXD, v); chk("R5 rx word", v, 32'hD0D0_0001);
    wr(A_STAT, 32'h0A);
    done_pulse();
    rd(A_STAT, v); chk("R8 done empty", v & 32'hA, 32'h2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_cmd();
    t_irq();
    t_txfifo();
    t_setwins();
    t_underflow();
    t_rx();
    t_overflow();
    t_done_rx();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule